// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which pending interrupt the core takes next. It watches five request lines: a non-maskable line, three vectored maskable lines (called high, middle and low here), and a non-vectored general request. Each line has its own trigger rule. The non-maskable line needs a rising edge and must still be high when sampled. The high line latches its rising edge. The middle, low and general lines are plain levels.

The core pulses `sample_i` at its instruction boundary. On that strobe the controller applies the global enable, the per-line masks and a fixed priority. It then produces either a one-cycle vector pulse or, for the general request, an active-low acknowledge. The acknowledge is held until external logic reports that it has supplied its opcode. Software restarts, the enable and disable commands, mask writes and a bus-hold request enter through their own inputs. A hold seen at the strobe is granted ahead of any interrupt.

The control is a four-state machine:
- `ST_IDLE` waits for a strobe or a software restart.
- `ST_VECTOR` presents a vector for one cycle.
- `ST_ACK` holds the acknowledge low.
- `ST_HOLD` grants the bus.

Its transitions are:
- IDLE to VECTOR on a software restart or an accepted vectored line.
- IDLE to ACK on an accepted general request.
- IDLE to HOLD on a strobe with hold requested.
- VECTOR to IDLE always.
- ACK to IDLE when the opcode supplier releases.
- HOLD to IDLE when the hold request drops.

Top module: `irqc_top`

## Requirements
- R1: Priority from highest to lowest is non-maskable, high, middle, low, general. `src_o` codes are 1, 2, 3, 4 and 5 for those lines, 6 for a software restart and 0 when idle.
- R2: An accepted vectored line raises `take_o` for exactly one cycle, in the cycle after the sampling edge. `vec_o` is then 0x0024 (non-maskable), 0x003C (high), 0x0034 (middle) or 0x002C (low). `vec_o` is 0 whenever `take_o` is low.
- R3: The non-maskable line is accepted regardless of the global enable and of all masks.
- R4: The non-maskable line is accepted only if a rising edge occurred at least one clock before the strobe and the input is still high at the strobe. It is not accepted again until a new rising edge occurs, and a pulse that falls before the strobe is lost.
- R5: A rising edge on the high line stays pending, even after the input falls, until that line is accepted. Acceptance clears it.
- R6: The middle, low and general lines are accepted only if they are high at the strobe edge.
- R7: Requests are evaluated only on a clock edge where `sample_i` is high and the controller is in `ST_IDLE`.
- R8: The global enable resets to 0. `ie_set_i` sets it and `ie_clr_i` clears it, with clear winning when both are high. Any hardware acceptance clears it. The four maskable lines need it set.
- R9: `mask_wr_i` loads `mask_val_i`. Bit 2 masks the high line, bit 1 the middle line and bit 0 the low line, and 1 means masked. All three are masked after reset. The general request has no per-line mask. A masked high-line edge stays latched.
- R10: `swr_i` with restart number n raises `take_o` the next cycle with `vec_o` = n*8 and `src_o` = 6. It leaves the global enable unchanged, and it wins over a strobe in the same cycle.
- R11: A strobe with `hold_i` high raises `hold_ack_o` from the next cycle for as long as `hold_i` stays high, and accepts nothing. Pending requests are served at a later strobe.
- R12: An accepted general request drives `ack_n_o` low from the next cycle until the cycle after `ack_release_i` is seen. `src_o` is 5 during that time and no vector is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sampling strobe from the core |
| nmi_i | input | 1 | Non-maskable request, edge plus level |
| vec_hi_i | input | 1 | High vectored request, latched edge |
| vec_mid_i | input | 1 | Middle vectored request, level |
| vec_lo_i | input | 1 | Low vectored request, level |
| gen_req_i | input | 1 | General non-vectored request, level |
| hold_i | input | 1 | Bus hold request |
| ie_set_i | input | 1 | Enable maskable interrupts |
| ie_clr_i | input | 1 | Disable maskable interrupts |
| mask_wr_i | input | 1 | Load per-line masks |
| mask_val_i | input | 3 | Mask values (bit2 high, bit1 middle, bit0 low) |
| swr_i | input | 1 | Software restart request |
| swr_num_i | input | NUM_W | Software restart number |
| ack_release_i | input | 1 | Opcode supplied, end acknowledge |
| take_o | output | 1 | Vector valid pulse |
| vec_o | output | VEC_W | Restart vector |
| src_o | output | 3 | Source code of the serviced request |
| ack_n_o | output | 1 | Active-low general acknowledge |
| hold_ack_o | output | 1 | Hold granted |

## Verification
A wrong edge latch or arming flag shows up at the next strobe, one clock after the sampling edge. It appears as a missing vector or an extra one, for example a second 0x0024 while the non-maskable input is held high. A stuck global enable or mask bit shows at the first strobe that finds a maskable line pending: a vector appears where none should, or is missing. Wrong arbitration shows as a wrong `src_o` and `vec_o` pair in that same cycle. A wrong state transition shows within a cycle as a vector pulse longer than one clock, an acknowledge that does not release, or a hold grant that outlives `hold_i`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NLINES   = 5;
    localparam int MASK_W   = 3;
    localparam int SRC_W    = 3;
    localparam int LINE_GEN = NLINES - 1;

    typedef enum logic [1:0] {
        TRIG_EDGE_LEVEL,
        TRIG_EDGE_LATCH,
        TRIG_LEVEL
    } trig_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_HI   = 3'd2,
        SRC_MID  = 3'd3,
        SRC_LO   = 3'd4,
        SRC_GEN  = 3'd5,
        SRC_SOFT = 3'd6
    } src_e;

    // Trigger rule per line, index 0 is highest priority.
    function automatic trig_e line_trig(int idx);
        if (idx == 0)      return TRIG_EDGE_LEVEL;
        else if (idx == 1) return TRIG_EDGE_LATCH;
        else               return TRIG_LEVEL;
    endfunction

    function automatic bit line_maskable(int idx);
        return idx != 0;
    endfunction

    // Mask bit that gates a line, -1 when the line has no per-line mask.
    function automatic int line_mask_bit(int idx);
        case (idx)
            1:       return 2;
            2:       return 1;
            3:       return 0;
            default: return -1;
        endcase
    endfunction

    // Restart position in half steps; the vector is eight bytes per step.
    function automatic int line_halfsteps(int idx);
        case (idx)
            0:       return 9;
            1:       return 15;
            2:       return 13;
            3:       return 11;
            default: return 0;
        endcase
    endfunction

    function automatic int line_vector(int idx);
        return line_halfsteps(idx) * 4;
    endfunction

endpackage

// File: rtl/irqc_sense.sv
module irqc_sense #(
    parameter bit KEEP_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic clr_i,
    output logic pend_o
);

    logic prev_q;
    logic flag_q;
    logic rise;

    assign rise = raw_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= raw_i;
            if (rise)
                flag_q <= 1'b1;
            else if (clr_i || (KEEP_HIGH && !raw_i))
                flag_q <= 1'b0;
        end
    end

    generate
        if (KEEP_HIGH) begin : g_edge_level
            assign pend_o = flag_q & raw_i;
        end else begin : g_edge_latch
            assign pend_o = flag_q;
        end
    endgenerate

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);

    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                gnt_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
    import irqc_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int NUM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              hold_i,
    input  logic              swr_i,
    input  logic [NUM_W-1:0]  swr_num_i,
    input  logic              ack_release_i,
    input  logic [NLINES-1:0] grant_i,
    input  logic              any_i,
    output logic              accept_o,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              ack_n_o,
    output logic              hold_ack_o
);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VECTOR,
        ST_ACK,
        ST_HOLD
    } state_e;

    state_e            state_q, state_n;
    logic [VEC_W-1:0]  vec_q;
    src_e              src_q;
    logic [VEC_W-1:0]  hw_vec;
    src_e              hw_src;
    logic [VEC_W-1:0]  soft_vec;
    logic              gen_win;

    assign gen_win  = grant_i[LINE_GEN];
    assign soft_vec = VEC_W'(swr_num_i) << 3;
    assign accept_o = (state_q == ST_IDLE) && !swr_i && sample_i && !hold_i && any_i;

    always_comb begin
        hw_vec = '0;
        hw_src = SRC_NONE;
        for (int i = 0; i < NLINES; i++) begin
            if (grant_i[i]) begin
                hw_vec = VEC_W'(line_vector(i));
                hw_src = src_e'(SRC_W'(i + 1));
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swr_i)
                    state_n = ST_VECTOR;
                else if (sample_i && hold_i)
                    state_n = ST_HOLD;
                else if (accept_o)
                    state_n = gen_win ? ST_ACK : ST_VECTOR;
            end
            ST_VECTOR: state_n = ST_IDLE;
            ST_ACK:    if (ack_release_i) state_n = ST_IDLE;
            ST_HOLD:   if (!hold_i) state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            src_q <= SRC_NONE;
        end else if (state_q == ST_IDLE) begin
            if (swr_i) begin
                vec_q <= soft_vec;
                src_q <= SRC_SOFT;
            end else if (accept_o) begin
                vec_q <= gen_win ? '0 : hw_vec;
                src_q <= hw_src;
            end
        end
    end

    always_comb begin
        take_o     = 1'b0;
        vec_o      = '0;
        src_o      = SRC_NONE;
        ack_n_o    = 1'b1;
        hold_ack_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VECTOR: begin
                take_o = 1'b1;
                vec_o  = vec_q;
                src_o  = src_q;
            end
            ST_ACK: begin
                ack_n_o = 1'b0;
                src_o   = src_q;
            end
            ST_HOLD: hold_ack_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int NUM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              nmi_i,
    input  logic              vec_hi_i,
    input  logic              vec_mid_i,
    input  logic              vec_lo_i,
    input  logic              gen_req_i,
    input  logic              hold_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_val_i,
    input  logic              swr_i,
    input  logic [NUM_W-1:0]  swr_num_i,
    input  logic              ack_release_i,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              ack_n_o,
    output logic              hold_ack_o
);

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] elig;
    logic [NLINES-1:0] grant;
    logic              any_req;
    logic              accept;
    logic              ie_q;
    logic [MASK_W-1:0] mask_q;

    assign raw = {gen_req_i, vec_lo_i, vec_mid_i, vec_hi_i, nmi_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
        end else begin
            if (accept || ie_clr_i)
                ie_q <= 1'b0;
            else if (ie_set_i)
                ie_q <= 1'b1;
            if (mask_wr_i)
                mask_q <= mask_val_i;
        end
    end

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            localparam trig_e TRIG = line_trig(i);
            localparam int    MB   = line_mask_bit(i);

            if (TRIG == TRIG_LEVEL) begin : g_lvl
                assign pend[i] = raw[i];
            end else begin : g_edge
                irqc_sense #(
                    .KEEP_HIGH(TRIG == TRIG_EDGE_LEVEL)
                ) u_sense (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .raw_i  (raw[i]),
                    .clr_i  (accept & grant[i]),
                    .pend_o (pend[i])
                );
            end

            if (!line_maskable(i)) begin : g_nm
                assign elig[i] = pend[i];
            end else if (MB < 0) begin : g_glob
                assign elig[i] = pend[i] & ie_q;
            end else begin : g_msk
                assign elig[i] = pend[i] & ie_q & ~mask_q[MB];
            end
        end
    endgenerate

    irqc_arbiter #(
        .N(NLINES)
    ) u_arb (
        .req_i (elig),
        .gnt_o (grant),
        .any_o (any_req)
    );

    irqc_fsm #(
        .VEC_W(VEC_W),
        .NUM_W(NUM_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample_i),
        .hold_i        (hold_i),
        .swr_i         (swr_i),
        .swr_num_i     (swr_num_i),
        .ack_release_i (ack_release_i),
        .grant_i       (grant),
        .any_i         (any_req),
        .accept_o      (accept),
        .take_o        (take_o),
        .vec_o         (vec_o),
        .src_o         (src_o),
        .ack_n_o       (ack_n_o),
        .hold_ack_o    (hold_ack_o)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int VEC_W = 16,
    parameter int NUM_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_i,
    input logic             nmi_i,
    input logic             gen_req_i,
    input logic             swr_num_i_dummy_unused_guard,
    input logic [NUM_W-1:0] swr_num_i,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [2:0]       src_o,
    input logic             ack_n_o,
    input logic             hold_ack_o
);

    assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_nmi_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == 3'd1) |-> (vec_o == VEC_W'(36)));

    assert_nmi_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == 3'd1) |-> $past(nmi_i));

    assert_hw_sampled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o != 3'd0 && src_o != 3'd6) |-> $past(sample_i));

    assert_gen_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> ($past(gen_req_i) && $past(sample_i)));

    assert_soft_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == 3'd6) |-> (vec_o == (VEC_W'($past(swr_num_i)) << 3)));

    assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_o |-> (!take_o && ack_n_o));

endmodule

bind irqc_top irqc_checker #(.VEC_W(VEC_W), .NUM_W(NUM_W)) u_chk (
    .clk                          (clk),
    .rst_n                        (rst_n),
    .sample_i                     (sample_i),
    .nmi_i                        (nmi_i),
    .gen_req_i                    (gen_req_i),
    .swr_num_i_dummy_unused_guard (swr_i),
    .swr_num_i                    (swr_num_i),
    .take_o                       (take_o),
    .vec_o                        (vec_o),
    .src_o                        (src_o),
    .ack_n_o                      (ack_n_o),
    .hold_ack_o                   (hold_ack_o)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_i = 0, nmi_i = 0, vec_hi_i = 0, vec_mid_i = 0, vec_lo_i = 0;
    logic        gen_req_i = 0, hold_i = 0, ie_set_i = 0, ie_clr_i = 0, mask_wr_i = 0;
    logic [2:0]  mask_val_i = 0;
    logic        swr_i = 0;
    logic [2:0]  swr_num_i = 0;
    logic        ack_release_i = 0;
    logic        take_o, ack_n_o, hold_ack_o;
    logic [15:0] vec_o;
    logic [2:0]  src_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .nmi_i(nmi_i),
        .vec_hi_i(vec_hi_i), .vec_mid_i(vec_mid_i), .vec_lo_i(vec_lo_i),
        .gen_req_i(gen_req_i), .hold_i(hold_i), .ie_set_i(ie_set_i),
        .ie_clr_i(ie_clr_i), .mask_wr_i(mask_wr_i), .mask_val_i(mask_val_i),
        .swr_i(swr_i), .swr_num_i(swr_num_i), .ack_release_i(ack_release_i),
        .take_o(take_o), .vec_o(vec_o), .src_o(src_o), .ack_n_o(ack_n_o),
        .hold_ack_o(hold_ack_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 vector, 2 acknowledge, 3 hold.
    int  m_state = 0;
    int  m_vec = 0, m_src = 0;
    bit  m_ie = 0, m_arm = 0, m_lat = 0, m_nprev = 0, m_hprev = 0;
    bit [2:0] m_mask = 3'b111;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_vec = 0; m_src = 0; m_ie = 0; m_arm = 0; m_lat = 0;
            m_nprev = 0; m_hprev = 0; m_mask = 3'b111;
        end else begin
            int win;
            bit acc;
            win = 0;
            acc = 0;
            if (m_arm && nmi_i) win = 1;
            else if (m_lat && m_ie && !m_mask[2]) win = 2;
            else if (vec_mid_i && m_ie && !m_mask[1]) win = 3;
            else if (vec_lo_i && m_ie && !m_mask[0]) win = 4;
            else if (gen_req_i && m_ie) win = 5;
            case (m_state)
                0: begin
                    if (swr_i) begin
                        m_state = 1; m_src = 6; m_vec = swr_num_i * 8;
                    end else if (sample_i && hold_i) begin
                        m_state = 3;
                    end else if (sample_i && win != 0) begin
                        acc = 1;
                        m_src = win;
                        case (win)
                            1: m_vec = 'h24;
                            2: m_vec = 'h3C;
                            3: m_vec = 'h34;
                            4: m_vec = 'h2C;
                            default: m_vec = 0;
                        endcase
                        m_state = (win == 5) ? 2 : 1;
                    end
                end
                1: m_state = 0;
                2: if (ack_release_i) m_state = 0;
                default: if (!hold_i) m_state = 0;
            endcase
            if (acc || ie_clr_i) m_ie = 0;
            else if (ie_set_i) m_ie = 1;
            if (mask_wr_i) m_mask = mask_val_i;
            if (nmi_i && !m_nprev) m_arm = 1;
            else if (!nmi_i || (acc && win == 1)) m_arm = 0;
            if (vec_hi_i && !m_hprev) m_lat = 1;
            else if (acc && win == 2) m_lat = 0;
            m_nprev = nmi_i;
            m_hprev = vec_hi_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 take", take_o, m_state == 1);
            check("R2 vec", vec_o, (m_state == 1) ? m_vec : 0);
            check("R1 src", src_o, (m_state == 1 || m_state == 2) ? m_src : 0);
            check("R12 ack_n", ack_n_o, m_state != 2);
            check("R11 hold_ack", hold_ack_o, m_state == 3);
        end
    end

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic strobe();
        sample_i = 1; tick(); sample_i = 0;
    endtask

    task automatic ei();
        ie_set_i = 1; tick(); ie_set_i = 0;
    endtask

    task automatic setmask(input logic [2:0] v);
        mask_wr_i = 1; mask_val_i = v; tick(); mask_wr_i = 0;
    endtask

    task automatic pulse_hi();
        vec_hi_i = 1; tick(); vec_hi_i = 0;
    endtask

    task automatic expect_take(string tag, int src, int vec);
        check({tag, " take"}, take_o, 1);
        check({tag, " src"}, src_o, src);
        check({tag, " vec"}, vec_o, vec);
    endtask

    task automatic expect_none(string tag);
        check({tag, " no take"}, take_o, 0);
        check({tag, " no ack"}, ack_n_o, 1);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        check("reset take", take_o, 0);
        check("reset ack_n", ack_n_o, 1);
        check("reset hold_ack", hold_ack_o, 0);
        rst_n = 1;
        tick();

        // R8: enable is off after reset, R9 masks cleared here
        setmask(3'b000);
        gen_req_i = 1; vec_mid_i = 1;
        strobe();
        expect_none("R8 reset enable off");

        // R1 R6: middle wins over low and general
        vec_lo_i = 1;
        ei();
        strobe();
        expect_take("R1 mid", 3, 'h34);
        tick();
        check("R2 single pulse", take_o, 0);
        strobe();
        expect_none("R8 cleared on accept");

        ei(); vec_mid_i = 0;
        strobe();
        expect_take("R1 lo", 4, 'h2C);
        tick();
        ei(); vec_lo_i = 0;
        strobe();
        check("R12 ack low", ack_n_o, 0);
        check("R12 src", src_o, 5);
        check("R12 no vector", take_o, 0);
        tick(); tick();
        check("R12 ack held", ack_n_o, 0);
        ack_release_i = 1; tick(); ack_release_i = 0;
        check("R12 ack released", ack_n_o, 1);
        gen_req_i = 0;

        // R6: level pulse gone before strobe
        ei();
        vec_lo_i = 1; tick(); vec_lo_i = 0; tick();
        strobe();
        expect_none("R6 level lost");

        // R5: latched edge survives disabled period, cleared on accept
        ie_clr_i = 1; tick(); ie_clr_i = 0;
        pulse_hi();
        tick();
        ei();
        strobe();
        expect_take("R5 latched", 2, 'h3C);
        tick();
        ei();
        strobe();
        expect_none("R5 latch cleared");

        // R9: masked edge stays latched
        setmask(3'b100);
        pulse_hi();
        strobe();
        expect_none("R9 masked");
        setmask(3'b000);
        strobe();
        expect_take("R9 unmasked latched", 2, 'h3C);
        tick();

        // R3 R4: non-maskable with enable off and masks set
        setmask(3'b111);
        nmi_i = 1; tick();
        strobe();
        expect_take("R3 nmi", 1, 'h24);
        tick();
        strobe();
        expect_none("R4 no retake while high");
        nmi_i = 0; tick(); nmi_i = 1; tick(); nmi_i = 0; tick();
        strobe();
        expect_none("R4 fell before strobe");

        // R1: full priority chain
        setmask(3'b000);
        ei();
        pulse_hi();
        vec_mid_i = 1; nmi_i = 1; tick();
        strobe();
        expect_take("R1 nmi first", 1, 'h24);
        tick(); ei();
        strobe();
        expect_take("R1 hi second", 2, 'h3C);
        tick(); ei();
        strobe();
        expect_take("R1 mid third", 3, 'h34);
        tick();
        vec_mid_i = 0; nmi_i = 0; tick();

        // R11: hold before non-maskable
        nmi_i = 1; tick();
        hold_i = 1;
        strobe();
        check("R11 granted", hold_ack_o, 1);
        check("R11 no take", take_o, 0);
        tick(); tick();
        check("R11 held", hold_ack_o, 1);
        hold_i = 0; tick();
        check("R11 released", hold_ack_o, 0);
        strobe();
        expect_take("R11 nmi after hold", 1, 'h24);
        tick();
        nmi_i = 0;

        // R10: software restart wins over strobe, enable unchanged
        ei();
        vec_lo_i = 1;
        swr_i = 1; swr_num_i = 3'd5; sample_i = 1;
        tick();
        swr_i = 0; sample_i = 0;
        expect_take("R10 soft", 6, 'h28);
        tick();
        strobe();
        expect_take("R10 enable kept", 4, 'h2C);
        tick();
        vec_lo_i = 0;
        swr_i = 1; swr_num_i = 3'd7; tick(); swr_i = 0;
        expect_take("R10 soft7", 6, 'h38);
        tick();

        // R7: no evaluation without strobe
        ei();
        vec_mid_i = 1;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R7 no strobe", take_o, 0);
        end
        strobe();
        expect_take("R7 strobe", 3, 'h34);
        tick();
        vec_mid_i = 0;

        // R8: disable wins over enable
        ie_set_i = 1; ie_clr_i = 1; tick(); ie_set_i = 0; ie_clr_i = 0;
        gen_req_i = 1;
        strobe();
        expect_none("R8 clear wins");
        gen_req_i = 0;
        tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule